// File: doc/BRIEF.md
# Nibble Data Memory with Nibble, Byte and Bit Access

This block is the working data store of a small 4-bit controller: 64 words of 4 bits, reached through a 12-bit data address. One access port carries every memory operation the core issues. It can read or write one word. It can read or write an 8-bit pair of words starting at an even address. It can set, clear or test one bit of a word. The 12-bit address is sorted into three regions. The low 64 addresses reach the on-chip words. The top 128 addresses form a window for peripheral registers, which is signalled on a select output and kept away from the array. Everything in between is unpopulated.

Two more ports read and write the same array. A register port names four 4-bit working registers, which are the same words as the four lowest memory addresses. A stack port pushes and pops nibbles in the upper half of the array, using a pointer that is held inside the window from 020H to 03FH. Writes take effect on the clock edge. Reads come straight from the stored words, with no register in the path.

Top module: `nibble_ram`

## Requirements
- R1: After a synchronous active-low reset, every word reads 0, the stack pointer holds the empty value 040H, and `acc_err`, `sp_ovf` and `sp_udf` are low.
- R2: Op code 1 writes `acc_wdata[3:0]` into the addressed word at the clock edge. Op code 0 returns that word on `acc_rdata[3:0]`, with bits 7:4 zero. The read is combinational from the stored word, so it shows the new value in the cycle after the write.
- R3: Byte ops (2 = read, 3 = write) at an even RAM address cover the word at the address, which holds bits 3:0, and the word at address+1, which holds bits 7:4.
- R4: A byte op at an odd address changes no word, returns 8'hFF, and raises `acc_err` for the one cycle after the access.
- R5: Op 4 sets and op 5 clears bit `acc_bit` of the addressed word, and the other three bits keep their values. For every RAM op, `acc_bit_out` shows bit `acc_bit` of the addressed word as it is before the edge. Op 6 is a test only and writes nothing.
- R6: Addresses 000H to 03FH reach the array. Addresses F80H to FFFH raise `periph_sel` while `acc_en` is high and never write the array. Any access outside the array returns 8'hFF on `acc_rdata` and 1 on `acc_bit_out`.
- R7: A write, set or clear at an address from 040H to F7FH changes nothing and raises `acc_err` for one cycle. Reads there, and accesses in the peripheral window, leave `acc_err` low.
- R8: Register port index i (0 to 3) reads and writes the same word as memory address i.
- R9: A push stores `sp_wdata` at the pointer minus one and then moves the pointer down by one. `sp_rdata` shows the word at the pointer. A pop moves the pointer up by one.
- R10: A push with the pointer at 020H, or a pop with the pointer at 040H, leaves the pointer and the array unchanged and raises `sp_ovf` or `sp_udf` for one cycle. The pointer always stays between 020H and 040H.
- R11: A push and a pop in the same cycle do nothing.
- R12: When several writes target one word in the same cycle, the stack write wins over the register port, and the register port wins over the access port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access port request valid |
| acc_op | input | 3 | Access operation code (0 to 6) |
| acc_addr | input | 12 | Data address |
| acc_bit | input | 2 | Bit index for bit operations |
| acc_wdata | input | 8 | Write data (bits 3:0 for nibble writes) |
| acc_rdata | output | 8 | Read data for the addressed word or pair |
| acc_bit_out | output | 1 | Selected bit of the addressed word |
| periph_sel | output | 1 | Access falls in the peripheral window |
| acc_err | output | 1 | One-cycle error for the previous access |
| gr_idx | input | 2 | Working-register index |
| gr_we | input | 1 | Working-register write enable |
| gr_wdata | input | 4 | Working-register write data |
| gr_rdata | output | 4 | Working-register read data |
| sp_push | input | 1 | Stack push request |
| sp_pop | input | 1 | Stack pop request |
| sp_wdata | input | 4 | Data to push |
| sp_rdata | output | 4 | Word at the stack pointer (all ones when empty) |
| sp_value | output | 7 | Current stack pointer |
| sp_ovf | output | 1 | One-cycle push-when-full flag |
| sp_udf | output | 1 | One-cycle pop-when-empty flag |

## Verification
The bench builds the block with its default parameters: 64 words, a 12-bit address, the stack window 020H to 03FH and the peripheral base F80H. With these values the whole stack can be filled in 32 pushes, so both the full and the empty stops are reached. The top word 03FH and the last pair 03EH/03FH can be written. Addresses on each side of every region edge (03FH/040H and F7FH/F80H) can be driven as single vectors.

// File: rtl/nram_pkg.sv
// Shared types for the nibble data memory: access operation codes and
// address region tags. Assumes a 3-bit operation field on the access port.
package nram_pkg;

    typedef enum logic [2:0] {
        OP_NIB_RD  = 3'd0,
        OP_NIB_WR  = 3'd1,
        OP_BYTE_RD = 3'd2,
        OP_BYTE_WR = 3'd3,
        OP_BIT_SET = 3'd4,
        OP_BIT_CLR = 3'd5,
        OP_BIT_TST = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        RGN_RAM    = 2'd0,
        RGN_PERIPH = 2'd1,
        RGN_NONE   = 2'd2
    } region_e;

    // True for the operations that cover an even/odd word pair.
    function automatic logic op_is_byte(input op_e op);
        return (op == OP_BYTE_RD) || (op == OP_BYTE_WR);
    endfunction

    // True for the operations that modify storage.
    function automatic logic op_is_write(input op_e op);
        return (op == OP_NIB_WR) || (op == OP_BYTE_WR) ||
               (op == OP_BIT_SET) || (op == OP_BIT_CLR);
    endfunction

endpackage

// File: rtl/nram_decode.sv
// Address region decoder. Sorts a data address into on-chip array, the
// peripheral window at the top of the space, or unpopulated space, and
// gives the word index inside the array. Assumes the array starts at 0
// and DEPTH is a power of two below PERIPH_BASE.
module nram_decode
    import nram_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DEPTH       = 64,
    parameter int unsigned PERIPH_BASE = 'hF80,
    localparam int         IW          = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IW-1:0]     idx
);

    // Region classification by address range.
    always_comb begin
        if (addr < ADDR_W'(DEPTH)) begin
            region = RGN_RAM;
        end else if (addr >= ADDR_W'(PERIPH_BASE)) begin
            region = RGN_PERIPH;
        end else begin
            region = RGN_NONE;
        end
    end

    // Word index is the low address bits.
    assign idx = addr[IW-1:0];

endmodule

// File: rtl/nram_array.sv
// Word storage with three write requesters. Each word has its own
// register and picks, by fixed priority, the stack write, then the
// register-port write, then the two access-port lanes. Assumes both
// access lanes never target the same word in one cycle.
module nram_array #(
    parameter int  DEPTH = 64,
    parameter int  DW    = 4,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stk_we,
    input  logic [IW-1:0]           stk_idx,
    input  logic [DW-1:0]           stk_data,
    input  logic                    reg_we,
    input  logic [IW-1:0]           reg_idx,
    input  logic [DW-1:0]           reg_data,
    input  logic                    lo_we,
    input  logic [IW-1:0]           lo_idx,
    input  logic [DW-1:0]           lo_data,
    input  logic                    hi_we,
    input  logic [IW-1:0]           hi_idx,
    input  logic [DW-1:0]           hi_data,
    output logic [DEPTH-1:0][DW-1:0] words
);

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DW-1:0] word_q;

        // Per-word write select by requester priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (stk_we && (stk_idx == IW'(w))) begin
                word_q <= stk_data;
            end else if (reg_we && (reg_idx == IW'(w))) begin
                word_q <= reg_data;
            end else if (lo_we && (lo_idx == IW'(w))) begin
                word_q <= lo_data;
            end else if (hi_we && (hi_idx == IW'(w))) begin
                word_q <= hi_data;
            end
        end

        assign words[w] = word_q;
    end

endmodule

// File: rtl/nram_stack.sv
// Stack pointer control. Holds a pointer inside [STACK_LO, STACK_HI+1],
// where STACK_HI+1 means empty. Push pre-decrements and writes, pop
// post-increments. Out-of-range moves are refused and flagged for one
// cycle. Assumes STACK_HI+1 <= DEPTH.
module nram_stack #(
    parameter int  DEPTH    = 64,
    parameter int  DW       = 4,
    parameter int  STACK_LO = 32,
    parameter int  STACK_HI = 63,
    localparam int IW       = $clog2(DEPTH),
    localparam int SPW      = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [DW-1:0]  push_data,
    output logic           wr_en,
    output logic [IW-1:0]  wr_idx,
    output logic [DW-1:0]  wr_data,
    output logic [SPW-1:0] sp,
    output logic           empty,
    output logic           ovf,
    output logic           udf
);

    localparam logic [SPW-1:0] SP_FULL  = SPW'(STACK_LO);
    localparam logic [SPW-1:0] SP_EMPTY = SPW'(STACK_HI + 1);

    logic do_push;
    logic do_pop;
    logic full;
    logic [SPW-1:0] sp_dec;

    // Single-direction requests only; both together cancel.
    assign do_push = push && !pop;
    assign do_pop  = pop && !push;
    assign full    = (sp == SP_FULL);
    assign empty   = (sp == SP_EMPTY);
    assign sp_dec  = sp - SPW'(1);

    // Push write request toward the array.
    assign wr_en   = do_push && !full;
    assign wr_idx  = sp_dec[IW-1:0];
    assign wr_data = push_data;

    // Pointer and one-cycle range flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= SP_EMPTY;
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            ovf <= do_push && full;
            udf <= do_pop && empty;
            if (wr_en) begin
                sp <= sp_dec;
            end else if (do_pop && !empty) begin
                sp <= sp + SPW'(1);
            end
        end
    end

endmodule

// File: rtl/nibble_ram.sv
// Nibble data memory top. One access port performs nibble, even-aligned
// byte and single-bit operations on a decoded address space. A register
// port aliases the lowest REGS words, and a stack port works in the
// window [STACK_LO, STACK_HI]. Reads are combinational from stored words.
// Assumes the core keeps acc_op within the defined codes.
module nibble_ram
    import nram_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DEPTH       = 64,
    parameter int          DW          = 4,
    parameter int          REGS        = 4,
    parameter int          STACK_LO    = 32,
    parameter int          STACK_HI    = 63,
    parameter int unsigned PERIPH_BASE = 'hF80,
    localparam int         IW          = $clog2(DEPTH),
    localparam int         BW          = $clog2(DW),
    localparam int         RW          = $clog2(REGS),
    localparam int         SPW         = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [2:0]        acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BW-1:0]     acc_bit,
    input  logic [2*DW-1:0]   acc_wdata,
    output logic [2*DW-1:0]   acc_rdata,
    output logic              acc_bit_out,
    output logic              periph_sel,
    output logic              acc_err,
    input  logic [RW-1:0]     gr_idx,
    input  logic              gr_we,
    input  logic [DW-1:0]     gr_wdata,
    output logic [DW-1:0]     gr_rdata,
    input  logic              sp_push,
    input  logic              sp_pop,
    input  logic [DW-1:0]     sp_wdata,
    output logic [DW-1:0]     sp_rdata,
    output logic [SPW-1:0]    sp_value,
    output logic              sp_ovf,
    output logic              sp_udf
);

    op_e                      op;
    region_e                  region;
    logic [IW-1:0]            idx;
    logic [IW-1:0]            idx_lo;
    logic [IW-1:0]            idx_hi;
    logic [DEPTH-1:0][DW-1:0] words;
    logic [DW-1:0]            nib;
    logic [DW-1:0]            bit_mask;
    logic                     in_ram;
    logic                     odd;
    logic                     is_byte;
    logic                     is_write;
    logic                     lo_we;
    logic                     hi_we;
    logic [DW-1:0]            lo_data;
    logic                     stk_we;
    logic [IW-1:0]            stk_idx;
    logic [DW-1:0]            stk_data;
    logic                     stk_empty;
    logic                     err_d;

    assign op = op_e'(acc_op);

    nram_decode #(
        .ADDR_W      (ADDR_W),
        .DEPTH       (DEPTH),
        .PERIPH_BASE (PERIPH_BASE)
    ) u_decode (
        .addr   (acc_addr),
        .region (region),
        .idx    (idx)
    );

    nram_stack #(
        .DEPTH    (DEPTH),
        .DW       (DW),
        .STACK_LO (STACK_LO),
        .STACK_HI (STACK_HI)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sp_push),
        .pop       (sp_pop),
        .push_data (sp_wdata),
        .wr_en     (stk_we),
        .wr_idx    (stk_idx),
        .wr_data   (stk_data),
        .sp        (sp_value),
        .empty     (stk_empty),
        .ovf       (sp_ovf),
        .udf       (sp_udf)
    );

    nram_array #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .stk_we   (stk_we),
        .stk_idx  (stk_idx),
        .stk_data (stk_data),
        .reg_we   (gr_we),
        .reg_idx  (IW'(gr_idx)),
        .reg_data (gr_wdata),
        .lo_we    (lo_we),
        .lo_idx   (idx_lo),
        .lo_data  (lo_data),
        .hi_we    (hi_we),
        .hi_idx   (idx_hi),
        .hi_data  (acc_wdata[2*DW-1:DW]),
        .words    (words)
    );

    // Operation and address attributes.
    assign in_ram   = (region == RGN_RAM);
    assign odd      = acc_addr[0];
    assign is_byte  = op_is_byte(op);
    assign is_write = op_is_write(op);
    assign nib      = words[idx];
    assign bit_mask = DW'(1) << acc_bit;

    // Word pair covered by a byte operation.
    always_comb begin
        idx_lo = idx;
        idx_hi = idx;
        if (is_byte) begin
            idx_lo = {idx[IW-1:1], 1'b0};
            idx_hi = {idx[IW-1:1], 1'b1};
        end
    end

    // Access-port write lanes.
    always_comb begin
        lo_we   = 1'b0;
        hi_we   = 1'b0;
        lo_data = acc_wdata[DW-1:0];
        if (acc_en && in_ram) begin
            unique case (op)
                OP_NIB_WR: lo_we = 1'b1;
                OP_BYTE_WR: begin
                    lo_we = !odd;
                    hi_we = !odd;
                end
                OP_BIT_SET: begin
                    lo_we   = 1'b1;
                    lo_data = nib | bit_mask;
                end
                OP_BIT_CLR: begin
                    lo_we   = 1'b1;
                    lo_data = nib & ~bit_mask;
                end
                default: begin
                    lo_we = 1'b0;
                end
            endcase
        end
    end

    // Read data by width; all ones outside the array or on a misaligned pair.
    always_comb begin
        if (!in_ram || (is_byte && odd)) begin
            acc_rdata = '1;
        end else if (is_byte) begin
            acc_rdata = {words[idx_hi], words[idx_lo]};
        end else begin
            acc_rdata = {{DW{1'b0}}, nib};
        end
    end

    // Bit view of the addressed word.
    assign acc_bit_out = in_ram ? nib[acc_bit] : 1'b1;

    // Peripheral window select.
    assign periph_sel = acc_en && (region == RGN_PERIPH);

    // Register port and stack read views.
    assign gr_rdata = words[IW'(gr_idx)];
    assign sp_rdata = stk_empty ? '1 : words[sp_value[IW-1:0]];

    // Error conditions: misaligned pair, or modify in unpopulated space.
    assign err_d = acc_en && ((is_byte && odd) ||
                              (is_write && (region == RGN_NONE)));

    // One-cycle registered error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_err <= 1'b0;
        end else begin
            acc_err <= err_d;
        end
    end

endmodule

// File: rtl/nram_chk.sv
// Property checker for nibble_ram, attached through bind. Observes ports
// only. Assumes the same parameter values as the bound instance.
module nram_chk #(
    parameter int          ADDR_W      = 12,
    parameter int          DEPTH       = 64,
    parameter int          DW          = 4,
    parameter int          REGS        = 4,
    parameter int          STACK_LO    = 32,
    parameter int          STACK_HI    = 63,
    parameter int unsigned PERIPH_BASE = 'hF80,
    localparam int         RW          = $clog2(REGS),
    localparam int         SPW         = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic [2:0]        acc_op,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [2*DW-1:0]   acc_rdata,
    input logic              acc_err,
    input logic              periph_sel,
    input logic [RW-1:0]     gr_idx,
    input logic [DW-1:0]     gr_rdata,
    input logic              sp_push,
    input logic              sp_pop,
    input logic [SPW-1:0]    sp_value,
    input logic              sp_ovf,
    input logic              sp_udf
);

    logic byte_op;
    logic unpop;
    logic nib_rd_reg;

    assign byte_op    = (acc_op == 3'd2) || (acc_op == 3'd3);
    assign unpop      = (acc_addr >= ADDR_W'(DEPTH)) && (acc_addr < ADDR_W'(PERIPH_BASE));
    assign nib_rd_reg = acc_en && (acc_op == 3'd0) && (acc_addr == ADDR_W'(gr_idx));

    AST_ODD_BYTE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && byte_op && acc_addr[0]) |=> acc_err); // R4

    AST_UNPOP_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && unpop) |-> (acc_rdata == '1)); // R6

    AST_PERIPH_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_sel && !(byte_op && acc_addr[0])) |=> !acc_err); // R7

    AST_REG_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        nib_rd_reg |-> (acc_rdata[DW-1:0] == gr_rdata)); // R8

    AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_value >= SPW'(STACK_LO)) && (sp_value <= SPW'(STACK_HI + 1))); // R10

    AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_push && !sp_pop && (sp_value == SPW'(STACK_LO))) |=>
        (sp_ovf && (sp_value == $past(sp_value)))); // R10

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_pop && !sp_push && (sp_value == SPW'(STACK_HI + 1))) |=>
        (sp_udf && (sp_value == $past(sp_value)))); // R10

    AST_PAIR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_push && sp_pop) |=> ($stable(sp_value) && !sp_ovf && !sp_udf)); // R11

endmodule

bind nibble_ram nram_chk #(
    .ADDR_W      (ADDR_W),
    .DEPTH       (DEPTH),
    .DW          (DW),
    .REGS        (REGS),
    .STACK_LO    (STACK_LO),
    .STACK_HI    (STACK_HI),
    .PERIPH_BASE (PERIPH_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_op     (acc_op),
    .acc_addr   (acc_addr),
    .acc_rdata  (acc_rdata),
    .acc_err    (acc_err),
    .periph_sel (periph_sel),
    .gr_idx     (gr_idx),
    .gr_rdata   (gr_rdata),
    .sp_push    (sp_push),
    .sp_pop     (sp_pop),
    .sp_value   (sp_value),
    .sp_ovf     (sp_ovf),
    .sp_udf     (sp_udf)
);

// File: tb/nibble_ram_tb.sv
module nibble_ram_tb;

    localparam int NVEC = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_op = '0;
    logic [11:0] acc_addr = '0;
    logic [1:0]  acc_bit = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        acc_bit_out;
    logic        periph_sel;
    logic        acc_err;
    logic [1:0]  gr_idx = '0;
    logic        gr_we = 1'b0;
    logic [3:0]  gr_wdata = '0;
    logic [3:0]  gr_rdata;
    logic        sp_push = 1'b0;
    logic        sp_pop = 1'b0;
    logic [3:0]  sp_wdata = '0;
    logic [3:0]  sp_rdata;
    logic [6:0]  sp_value;
    logic        sp_ovf;
    logic        sp_udf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nibble_ram u_dut (
        .clk (clk), .rst_n (rst_n),
        .acc_en (acc_en), .acc_op (acc_op), .acc_addr (acc_addr),
        .acc_bit (acc_bit), .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
        .acc_bit_out (acc_bit_out), .periph_sel (periph_sel), .acc_err (acc_err),
        .gr_idx (gr_idx), .gr_we (gr_we), .gr_wdata (gr_wdata), .gr_rdata (gr_rdata),
        .sp_push (sp_push), .sp_pop (sp_pop), .sp_wdata (sp_wdata),
        .sp_rdata (sp_rdata), .sp_value (sp_value), .sp_ovf (sp_ovf), .sp_udf (sp_udf)
    );

    // Vector: req[39:36] op[35:33] addr[32:21] bit[20:19] wdata[18:11]
    //         exp_rdata[10:3] exp_bit_out[2] exp_periph_sel[1] exp_err[0]
    localparam logic [39:0] VEC [NVEC] = '{
        {4'd2, 3'd1, 12'h005, 2'd0, 8'h0A, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 write
        {4'd2, 3'd0, 12'h005, 2'd1, 8'h00, 8'h0A, 1'b1, 1'b0, 1'b0}, // R2 read back
        {4'd3, 3'd3, 12'h010, 2'd0, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0}, // R3 pair write
        {4'd3, 3'd2, 12'h010, 2'd0, 8'h00, 8'hC3, 1'b1, 1'b0, 1'b0}, // R3 pair read
        {4'd3, 3'd0, 12'h011, 2'd3, 8'h00, 8'h0C, 1'b1, 1'b0, 1'b0}, // R3 high word
        {4'd4, 3'd3, 12'h011, 2'd0, 8'h55, 8'hFF, 1'b0, 1'b0, 1'b1}, // R4 odd pair
        {4'd4, 3'd2, 12'h010, 2'd0, 8'h00, 8'hC3, 1'b1, 1'b0, 1'b0}, // R4 unchanged
        {4'd5, 3'd4, 12'h005, 2'd2, 8'h00, 8'h0A, 1'b0, 1'b0, 1'b0}, // R5 set
        {4'd5, 3'd0, 12'h005, 2'd2, 8'h00, 8'h0E, 1'b1, 1'b0, 1'b0}, // R5 after set
        {4'd5, 3'd5, 12'h005, 2'd1, 8'h00, 8'h0E, 1'b1, 1'b0, 1'b0}, // R5 clear
        {4'd5, 3'd6, 12'h005, 2'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 1'b0}, // R5 test
        {4'd7, 3'd1, 12'h100, 2'd0, 8'h07, 8'hFF, 1'b1, 1'b0, 1'b1}, // R7 write hole
        {4'd7, 3'd0, 12'h100, 2'd0, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0}, // R7 read hole
        {4'd7, 3'd4, 12'h040, 2'd0, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1}, // R7 set at edge
        {4'd6, 3'd1, 12'hF80, 2'd0, 8'h05, 8'hFF, 1'b1, 1'b1, 1'b0}, // R6 periph base
        {4'd6, 3'd2, 12'hFFE, 2'd0, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0}, // R6 periph top
        {4'd6, 3'd0, 12'hF7F, 2'd0, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0}, // R6 below window
        {4'd2, 3'd1, 12'h03F, 2'd0, 8'h09, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 top word
        {4'd2, 3'd0, 12'h03F, 2'd0, 8'h00, 8'h09, 1'b1, 1'b0, 1'b0}, // R2 top read
        {4'd3, 3'd3, 12'h03E, 2'd0, 8'h81, 8'h90, 1'b0, 1'b0, 1'b0}, // R3 last pair
        {4'd3, 3'd2, 12'h03E, 2'd0, 8'h00, 8'h81, 1'b1, 1'b0, 1'b0}, // R3 last pair rd
        {4'd8, 3'd1, 12'h002, 2'd0, 8'h06, 8'h00, 1'b0, 1'b0, 1'b0}, // R8 via memory
        {4'd6, 3'd0, 12'h000, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}  // R6 no alias
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access: drive at negedge, check combinational outputs, then the error pulse.
    task automatic do_op(input string req, input logic [2:0] op, input logic [11:0] addr,
                         input logic [1:0] bsel, input logic [7:0] wd,
                         input logic [7:0] erd, input logic ebo, input logic eps,
                         input logic eerr);
        @(negedge clk);
        acc_en = 1'b1; acc_op = op; acc_addr = addr; acc_bit = bsel; acc_wdata = wd;
        #1;
        chk(req, "acc_rdata", 32'(acc_rdata), 32'(erd));
        chk(req, "acc_bit_out", 32'(acc_bit_out), 32'(ebo));
        chk(req, "periph_sel", 32'(periph_sel), 32'(eps));
        @(posedge clk);
        #1;
        chk(req, "acc_err", 32'(acc_err), 32'(eerr));
        acc_en = 1'b0;
    endtask

    // One stack cycle.
    task automatic stk(input logic push, input logic pop, input logic [3:0] d);
        @(negedge clk);
        sp_push = push; sp_pop = pop; sp_wdata = d;
        @(posedge clk);
        #1;
        sp_push = 1'b0; sp_pop = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "sp_value", 32'(sp_value), 32'h40);
        chk("R1", "acc_err", 32'(acc_err), 0);
        chk("R1", "sp_ovf", 32'(sp_ovf), 0);
        chk("R1", "sp_udf", 32'(sp_udf), 0);
        chk("R1", "gr_rdata", 32'(gr_rdata), 0);
        chk("R1", "sp_rdata empty", 32'(sp_rdata), 32'hF);

        for (int i = 0; i < NVEC; i++) begin
            string r;
            r = $sformatf("R%0d/vec%0d", VEC[i][39:36], i);
            do_op(r, VEC[i][35:33], VEC[i][32:21], VEC[i][20:19], VEC[i][18:11],
                  VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R8 register port sees memory write, memory sees register write
        @(negedge clk);
        gr_idx = 2'd2;
        #1;
        chk("R8", "gr_rdata idx2", 32'(gr_rdata), 32'h6);
        gr_idx = 2'd1; gr_we = 1'b1; gr_wdata = 4'hB;
        @(posedge clk);
        #1;
        gr_we = 1'b0;
        do_op("R8", 3'd0, 12'h001, 2'd0, 8'h00, 8'h0B, 1'b1, 1'b0, 1'b0);

        // R12 register port beats access port on the same word
        @(negedge clk);
        gr_idx = 2'd3; gr_we = 1'b1; gr_wdata = 4'h5;
        acc_en = 1'b1; acc_op = 3'd1; acc_addr = 12'h003; acc_wdata = 8'h0A;
        @(posedge clk);
        #1;
        gr_we = 1'b0; acc_en = 1'b0;
        chk("R12", "gr_rdata idx3", 32'(gr_rdata), 32'h5);

        // R10 pop when empty
        stk(1'b0, 1'b1, 4'h0);
        chk("R10", "sp_udf", 32'(sp_udf), 1);
        chk("R10", "sp_value after empty pop", 32'(sp_value), 32'h40);

        // R9 fill the stack
        for (int k = 0; k < 32; k++) begin
            stk(1'b1, 1'b0, 4'(k));
        end
        chk("R9", "sp_value full", 32'(sp_value), 32'h20);
        chk("R9", "sp_rdata top", 32'(sp_rdata), 32'hF);

        // R10 push when full
        stk(1'b1, 1'b0, 4'h3);
        chk("R10", "sp_ovf", 32'(sp_ovf), 1);
        chk("R10", "sp_value after full push", 32'(sp_value), 32'h20);
        chk("R10", "sp_rdata unchanged", 32'(sp_rdata), 32'hF);
        do_op("R9", 3'd0, 12'h03F, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        do_op("R9", 3'd0, 12'h021, 2'd0, 8'h00, 8'h0E, 1'b0, 1'b0, 1'b0);

        // R11 push and pop together
        stk(1'b1, 1'b1, 4'h7);
        chk("R11", "sp_value", 32'(sp_value), 32'h20);
        chk("R11", "sp_ovf", 32'(sp_ovf), 0);
        chk("R11", "sp_udf", 32'(sp_udf), 0);

        // R9 pop
        stk(1'b0, 1'b1, 4'h0);
        chk("R9", "sp_value after pop", 32'(sp_value), 32'h21);
        chk("R9", "sp_rdata after pop", 32'(sp_rdata), 32'hE);
        chk("R9", "sp_udf", 32'(sp_udf), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule